// File: doc/BRIEF.md
# Per-Channel Noise Amplitude Monitor

This block measures how much the quiet baseline of each ADC channel wanders. For every channel it keeps the largest and the smallest sample seen since the last readout. It reports the difference between them as a 5-bit noise amplitude. The amplitude saturates at 31 counts, because large noise is not expected and a larger figure would carry no useful meaning.

Real input pulses must not count as noise. Each channel therefore blanks a guard interval of `GUARD` valid samples on both sides of any sample flagged by the upstream pulse detector. To blank samples that arrive before a pulse, samples are held in a delay line of `GUARD` stages, so a sample reaches the tracker only `GUARD` valid samples after it arrives. By then, any pulse that follows it closely enough has already been seen. Samples after a pulse are blanked by a down-counter, which is reloaded on every pulse flag.

A per-channel read strobe returns the amplitude shown in the same cycle. At the clock edge that ends the strobe, both extremes are re-seeded from the present sample. The present sample is the one accepted in that same cycle, or otherwise the last one accepted before it. Measurement then starts afresh.

Top module: `noise_amp_monitor`

## Requirements
- R1: After reset, and for as long as no sample has passed the blanking logic, every channel's noise output is 0.
- R2: Once samples have been accepted, a channel's noise output equals the largest accepted sample minus the smallest accepted sample since the last read, taken as unsigned values.
- R3: When that difference exceeds 31, the output is 31.
- R4: A read strobe sets both extremes to the last accepted sample, so in the next cycle the output is 0. Later samples are measured against that seed.
- R5: When a read strobe and an accepted sample fall in the same cycle, that sample becomes the seed.
- R6: A sample takes part in the measurement only when `GUARD` further valid samples have arrived on its channel after it. The sample is folded in at the clock edge of the later of those arrivals.
- R7: A sample is excluded if a pulse flag arrives with any of the following `GUARD` valid samples.
- R8: A sample is excluded if a pulse flag came with it, or with any of the `GUARD` valid samples before it. A sample `GUARD+1` positions away from every pulse is counted.
- R9: In a cycle with the sample-valid strobe low, the sample and pulse inputs are ignored. Without a read strobe, the output holds its value.
- R10: Each channel uses only its own sample slice, pulse flag and read strobe. Its output does not depend on any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | A new sample is present on all channels |
| smp_data | input | NCH*SW | Unsigned samples, channel c in bits [c*SW +: SW] |
| pulse_det | input | NCH | Per-channel pulse flag, qualified by smp_valid |
| rd_stb | input | NCH | Per-channel read strobe |
| noise_out | output | NCH*5 | Noise amplitude, channel c in bits [c*5 +: 5] |

## Verification
The bench builds the block with two channels, 8-bit samples and a guard of 3 samples. With a guard this short, the pulse positions that fall just inside and just outside the blanking interval can be placed by hand. A long stream of a few thousand cycles then crosses many such intervals, overlapping pulses and read strobes. The 8-bit sample range lets both small spreads and spreads far beyond 31 occur often. Both channels are checked against a model in every cycle, so a fault that mixes the channels or shifts the guard by one sample shows up as a mismatch.

// File: rtl/nam_pkg.sv
package nam_pkg;
    localparam int NOISE_W   = 5;
    localparam int NOISE_MAX = (1 << NOISE_W) - 1;
endpackage

// File: rtl/nam_guard.sv
module nam_guard #(
    parameter int SW    = 12,
    parameter int GUARD = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          smp_valid_i,
    input  logic [SW-1:0] smp_data_i,
    input  logic          pulse_i,
    output logic          acc_valid_o,
    output logic [SW-1:0] acc_data_o
);
    localparam int HOLD = 2 * GUARD;
    localparam int CW   = $clog2(HOLD + 1);

    typedef struct packed {
        logic [GUARD-1:0][SW-1:0] dly;
        logic [GUARD-1:0]         fill;
        logic [CW-1:0]            cnt;
    } guard_st_t;

    guard_st_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        acc_data_o  = st_q.dly[GUARD-1];
        acc_valid_o = smp_valid_i && st_q.fill[GUARD-1] && !pulse_i
                      && (st_q.cnt == '0);
        if (smp_valid_i) begin
            st_d.dly[0]  = smp_data_i;
            st_d.fill[0] = 1'b1;
            for (int k = 1; k < GUARD; k++) begin
                st_d.dly[k]  = st_q.dly[k-1];
                st_d.fill[k] = st_q.fill[k-1];
            end
            if (pulse_i)
                st_d.cnt = CW'(HOLD);
            else if (st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(HOLD));

    // R7
    pulse_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_valid_i && pulse_i) |=> (st_q.cnt != '0));
endmodule

// File: rtl/nam_tracker.sv
module nam_tracker
    import nam_pkg::*;
#(
    parameter int SW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid_i,
    input  logic [SW-1:0]      acc_data_i,
    input  logic               rd_i,
    output logic [NOISE_W-1:0] noise_o
);
    typedef struct packed {
        logic [SW-1:0] hi;
        logic [SW-1:0] lo;
        logic [SW-1:0] last;
        logic          seen;
    } trk_st_t;

    trk_st_t       st_d, st_q;
    logic [SW-1:0] seed;
    logic [SW-1:0] span;

    always_comb begin
        st_d = st_q;
        seed = acc_valid_i ? acc_data_i : st_q.last;
        if (rd_i) begin
            st_d.hi = seed;
            st_d.lo = seed;
        end else if (acc_valid_i) begin
            if (!st_q.seen) begin
                st_d.hi = acc_data_i;
                st_d.lo = acc_data_i;
            end else begin
                if (acc_data_i > st_q.hi) st_d.hi = acc_data_i;
                if (acc_data_i < st_q.lo) st_d.lo = acc_data_i;
            end
        end
        if (acc_valid_i) begin
            st_d.seen = 1'b1;
            st_d.last = acc_data_i;
        end
    end

    always_comb begin
        span = st_q.hi - st_q.lo;
        if (!st_q.seen)
            noise_o = '0;
        else if (span > SW'(NOISE_MAX))
            noise_o = NOISE_W'(NOISE_MAX);
        else
            noise_o = span[NOISE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R2
    order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.seen |-> (st_q.hi >= st_q.lo));

    // R4
    read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_i |=> (noise_o == '0));

    // R2
    grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid_i && !rd_i) |=> (noise_o >= $past(noise_o)));
endmodule

// File: rtl/nam_channel.sv
module nam_channel
    import nam_pkg::*;
#(
    parameter int SW    = 12,
    parameter int GUARD = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               smp_valid_i,
    input  logic [SW-1:0]      smp_data_i,
    input  logic               pulse_i,
    input  logic               rd_i,
    output logic [NOISE_W-1:0] noise_o
);
    logic          acc_valid;
    logic [SW-1:0] acc_data;

    nam_guard #(.SW(SW), .GUARD(GUARD)) u_guard (
        .clk         (clk),
        .rst_n       (rst_n),
        .smp_valid_i (smp_valid_i),
        .smp_data_i  (smp_data_i),
        .pulse_i     (pulse_i),
        .acc_valid_o (acc_valid),
        .acc_data_o  (acc_data)
    );

    nam_tracker #(.SW(SW)) u_trk (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid_i (acc_valid),
        .acc_data_i  (acc_data),
        .rd_i        (rd_i),
        .noise_o     (noise_o)
    );

    // R9
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!smp_valid_i && !rd_i) |=> $stable(noise_o));
endmodule

// File: rtl/noise_amp_monitor.sv
module noise_amp_monitor
    import nam_pkg::*;
#(
    parameter int NCH   = 16,
    parameter int SW    = 12,
    parameter int GUARD = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   smp_valid,
    input  logic [NCH*SW-1:0]      smp_data,
    input  logic [NCH-1:0]         pulse_det,
    input  logic [NCH-1:0]         rd_stb,
    output logic [NCH*NOISE_W-1:0] noise_out
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        nam_channel #(.SW(SW), .GUARD(GUARD)) u_ch (
            .clk         (clk),
            .rst_n       (rst_n),
            .smp_valid_i (smp_valid),
            .smp_data_i  (smp_data[ch*SW +: SW]),
            .pulse_i     (pulse_det[ch]),
            .rd_i        (rd_stb[ch]),
            .noise_o     (noise_out[ch*NOISE_W +: NOISE_W])
        );
    end
endmodule

// File: tb/tb_noise_amp_monitor.sv
module tb_noise_amp_monitor;
    localparam int NCH  = 2;
    localparam int SW   = 8;
    localparam int G    = 3;
    localparam int MAXS = 8192;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [NCH-1:0]    pulse_det = '0;
    logic [NCH-1:0]    rd_stb = '0;
    logic [NCH*5-1:0]  noise_out;

    noise_amp_monitor #(.NCH(NCH), .SW(SW), .GUARD(G)) dut (
        .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
        .pulse_det(pulse_det), .rd_stb(rd_stb), .noise_out(noise_out)
    );

    always #10 clk = ~clk;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string tag   = "R1";

    int hist [NCH][MAXS];
    bit pfl  [NCH][MAXS];
    int cnt  [NCH];
    int mx   [NCH];
    int mn   [NCH];
    int last [NCH];
    bit seen [NCH];

    function automatic int expect_of(int c);
        int s;
        if (!seen[c]) return 0;
        s = mx[c] - mn[c];
        return (s > 31) ? 31 : s;
    endfunction

    task automatic check(string t, int c, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s ch%0d: noise=%0d expected %0d", t, c, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int c = 0; c < NCH; c++) begin
            cnt[c] = 0; mx[c] = 0; mn[c] = 0; last[c] = 0; seen[c] = 0;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; smp_valid = 1'b0; smp_data = '0; pulse_det = '0; rd_stb = '0;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        model_clear();
    endtask

    // One cycle: check outputs for the current state, drive inputs, advance model.
    task automatic step(bit v, int d0, int d1, bit p0, bit p1, bit r0, bit r1);
        int  dv [NCH];
        bit  pv [NCH];
        bit  rv [NCH];
        @(negedge clk);
        for (int c = 0; c < NCH; c++)
            check(tag, c, int'(noise_out[c*5 +: 5]), expect_of(c));
        dv[0] = d0; dv[1] = d1; pv[0] = p0; pv[1] = p1; rv[0] = r0; rv[1] = r1;
        smp_valid = v;
        smp_data  = {SW'(d1), SW'(d0)};
        pulse_det = {p1, p0};
        rd_stb    = {r1, r0};
        for (int c = 0; c < NCH; c++) begin
            bit acc = 0;
            int ad  = 0;
            if (v) begin
                int i = cnt[c];
                int j = i - G;
                hist[c][i] = dv[c];
                pfl[c][i]  = pv[c];
                cnt[c]++;
                if (j >= 0) begin
                    bit blank = 0;
                    for (int k = ((j - G) < 0 ? 0 : j - G); k <= i; k++)
                        if (pfl[c][k]) blank = 1;
                    if (!blank) begin acc = 1; ad = hist[c][j]; end
                end
            end
            if (rv[c]) begin
                int sd = acc ? ad : last[c];
                mx[c] = sd; mn[c] = sd;
            end else if (acc) begin
                if (!seen[c]) begin mx[c] = ad; mn[c] = ad; end
                else begin
                    if (ad > mx[c]) mx[c] = ad;
                    if (ad < mn[c]) mn[c] = ad;
                end
            end
            if (acc) begin seen[c] = 1; last[c] = ad; end
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        finish_run();
    end

    initial begin
        do_reset();
        // R1: reset state, then output 0 until the first sample clears the delay line
        @(negedge clk);
        check("R1", 0, int'(noise_out[4:0]), 0);
        check("R1", 1, int'(noise_out[9:5]), 0);
        tag = "R1";
        step(1, 10, 5, 0, 0, 0, 0);
        step(1, 90, 5, 0, 0, 0, 0);
        step(1, 10, 5, 0, 0, 0, 0);

        // R6: a sample counts only after G further valid samples
        do_reset(); tag = "R6";
        step(1, 10, 7, 0, 0, 0, 0);
        step(1, 30, 7, 0, 0, 0, 0);
        step(0, 99, 7, 0, 0, 0, 0);
        step(1, 10, 7, 0, 0, 0, 0);
        step(1, 10, 7, 0, 0, 0, 0);
        step(1, 10, 7, 0, 0, 0, 0);
        step(1, 10, 7, 0, 0, 0, 0);
        step(0, 10, 7, 0, 0, 0, 0);

        // R3: saturation at 31
        do_reset(); tag = "R3";
        step(1, 0, 40, 0, 0, 0, 0);
        step(1, 200, 71, 0, 0, 0, 0);
        step(1, 32, 72, 0, 0, 0, 0);
        for (int k = 0; k < 5; k++) step(1, 31, 70, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0, 0, 0);

        // R4: read re-seeds from the last accepted sample
        tag = "R4";
        step(0, 0, 0, 0, 0, 1, 0);
        step(0, 0, 0, 0, 0, 0, 0);
        step(1, 50, 70, 0, 0, 0, 0);
        step(1, 20, 70, 0, 0, 0, 0);
        step(1, 31, 70, 0, 0, 0, 0);
        step(1, 31, 70, 0, 0, 0, 0);
        step(1, 31, 70, 0, 0, 0, 0);
        step(0, 31, 70, 0, 0, 0, 0);

        // R5: read together with an accepted sample seeds with that sample
        tag = "R5";
        step(1, 31, 70, 0, 0, 1, 1);
        step(1, 31, 70, 0, 0, 0, 0);
        step(1, 31, 70, 0, 0, 0, 0);
        step(0, 31, 70, 0, 0, 0, 0);

        // R7 and R8: spikes just inside and just outside the guard interval
        do_reset(); tag = "R7";
        begin
            int seq [16] = '{50, 50, 40, 90, 50, 50, 50, 50, 50, 95, 60, 50, 50, 50, 50, 50};
            for (int k = 0; k < 16; k++) begin
                if (k >= 6) tag = "R8";
                step(1, seq[k], 50, k == 6, 0, 0, 0);
            end
            for (int k = 0; k < 4; k++) step(1, 50, 50, 0, 0, 0, 0);
        end

        // R9: valid low ignores data and pulses; output holds
        tag = "R9";
        for (int k = 0; k < 6; k++) step(0, 250, 0, 1, 1, 0, 0);
        for (int k = 0; k < 5; k++) step(1, 50, 50, 0, 0, 0, 0);

        // R10: channels independent
        do_reset(); tag = "R10";
        for (int k = 0; k < 12; k++)
            step(1, 100 + (k % 2) * 9, 60, 0, k == 5, 0, k == 8);
        for (int k = 0; k < 6; k++) step(1, 100, 20 + k * 3, 1, 0, 0, 0);

        // R2: long pseudo-random sweep
        do_reset(); tag = "R2";
        for (int k = 0; k < 4000; k++) begin
            bit v  = ($urandom % 4) != 0;
            int d0 = ($urandom % 16 == 0) ? int'($urandom % 256) : 100 + int'($urandom % 20);
            int d1 = ($urandom % 16 == 0) ? int'($urandom % 256) : 30 + int'($urandom % 12);
            bit p0 = ($urandom % 40) == 0;
            bit p1 = ($urandom % 40) == 0;
            bit r0 = ($urandom % 25) == 0;
            bit r1 = ($urandom % 25) == 0;
            step(v, d0, d1, p0, p1, r0, r1);
        end
        step(0, 0, 0, 0, 0, 0, 0);
        finish_run();
    end
endmodule